// File: doc/BRIEF.md
# Group Pass/Fail Status Accumulator

This design-for-test block sits inside a flash memory die and records the verify outcome of each memory block while a group of 64 blocks is exercised during burn-in. Every outcome arrives as a strobe carrying a block index and a fail bit, and the block stores it in a flag of its own. No tester action is needed. At the same time the block keeps one summary bit for the whole group. A tester can therefore decide pass or fail for 64 blocks in a single check instead of visiting each block in turn.

When the tester needs to know which blocks failed, it issues a status-read command and then toggles read-enable. Each falling edge of read-enable brings out the next eight stored flags on the 8-bit data output. A clear input empties the flags, the summary and the read position before the next group starts. Read-enable is asynchronous to the core clock, so it passes through a synchronizer before its edges are detected.

Top module: `group_status_acc`

## Requirements
- R1: A strobe with an index below 64 writes its fail bit (1 = fail, 0 = pass) into that block's flag and overwrites any earlier value.
- R2: `groupFail` is the sticky OR of every in-range fail bit written since the last clear. It rises one clock after a failing strobe and stays high even if that block is later rewritten as pass.
- R3: A clear sets all flags, `groupFail`, the read position and `dataOut` to zero one clock later. A strobe in the same cycle as a clear has no effect.
- R4: A strobe with an index of 64 or more changes no flag and leaves `groupFail` unchanged.
- R5: Each falling edge of `readEn` presents byte k of the flags, in which bit j holds block 8k+j. Successive falls give k = 0, 1, 2 and so on. The new byte appears on the third rising clock edge after the fall.
- R6: A status-read command returns the read position to byte 0, so the next fall presents blocks 0 to 7.
- R7: The fall after the one that presents byte 7 presents byte 0 again.
- R8: `dataOut` changes only after a falling edge of `readEn` or a clear. It stays stable while `readEn` is high, including across the rising edge of `readEn`.
- R9: After reset, `dataOut` and `groupFail` are zero and the read position is byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resStrobe | input | 1 | One-cycle pulse: a block's verify result is valid |
| resFail | input | 1 | Verify outcome, 1 = fail |
| resIndex | input | 7 | Block index of the result |
| clearAll | input | 1 | Empty the flags, the summary and the read position |
| statCmd | input | 1 | Status-read command, restarts readout at byte 0 |
| readEn | input | 1 | Asynchronous read-enable from the tester, idle high |
| dataOut | output | 8 | Current byte of stored flags |
| groupFail | output | 1 | Group summary, 1 if any block failed |

## Verification
Strobe and clear results register once, so the bench drives them just after a falling clock edge and samples `groupFail` at the next falling edge. This is half a cycle after the edge that updates it. A byte for a read-enable fall is due three rising edges after the fall: two synchronizer stages and the output register. The bench therefore holds `readEn` low for four clocks before it samples `dataOut`. It then keeps `readEn` high for three more clocks and samples again to confirm the byte held. Status-read and clear pulses are followed by at least one clock before the next fall, so the read position they set is in place when the fall arrives.

// File: rtl/gsa_pkg.sv
package gsa_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic clr;   // empty flags, summary and output register
    logic load;  // capture the selected byte into the output register
    logic hold;  // synchronized read-enable has been high for two samples
  } ctlStrobe_t;

endpackage

// File: rtl/gsa_ctrl.sv
module gsa_ctrl #(
  parameter int NUM_BYTES   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clearAll,
  input  logic                    statCmd,
  input  logic                    readEn,
  output gsa_pkg::ctlStrobe_t     ctl,
  output logic [PTR_W-1:0]        bytePtr
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_BYTES - 1);

  logic [SYNC_STAGES-1:0] reSync;
  logic                   reDly;
  logic                   reLevel;
  logic                   reFall;

  // Read-enable idles high, so the synchronizer resets to ones and
  // leaving reset produces no edge.
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) reSync <= '1;
        else       reSync <= {reSync[SYNC_STAGES-2:0], readEn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) reSync <= '1;
        else       reSync <= readEn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reDly <= 1'b1;
    else       reDly <= reLevel;
  end

  assign reLevel = reSync[SYNC_STAGES-1];
  assign reFall  = reDly & ~reLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    bytePtr <= '0;
    else if (clearAll || statCmd) bytePtr <= '0;
    else if (reFall)              bytePtr <= (bytePtr == LAST_PTR) ? '0 : bytePtr + 1'b1;
  end

  always_comb begin
    ctl.clr  = clearAll;
    ctl.load = reFall & ~clearAll;
    ctl.hold = reLevel & reDly;
  end

  // R6: a status-read command restarts readout at byte 0
  assert_cmd_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statCmd && !clearAll) |=> (bytePtr == '0));

  // R7: the position after the last byte is byte 0
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reFall && !clearAll && !statCmd && bytePtr == LAST_PTR) |=> (bytePtr == '0));

  // R5: every other fall advances the read position by one
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reFall && !clearAll && !statCmd && bytePtr != LAST_PTR)
      |=> (bytePtr == $past(bytePtr) + 1'b1));

  // R3: a clear returns the read position to 0
  assert_clear_ptr_R3: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (bytePtr == '0));

endmodule

// File: rtl/gsa_datapath.sv
module gsa_datapath #(
  parameter int NUM_BLOCKS = 64,
  parameter int BUS_W      = 8,
  parameter int IDX_W      = 7,
  localparam int NUM_BYTES = NUM_BLOCKS / BUS_W,
  localparam int PTR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gsa_pkg::ctlStrobe_t   ctl,
  input  logic [PTR_W-1:0]      bytePtr,
  input  logic                  resStrobe,
  input  logic                  resFail,
  input  logic [IDX_W-1:0]      resIndex,
  output logic [BUS_W-1:0]      dataOut,
  output logic                  groupFail
);

  logic [NUM_BLOCKS-1:0] flagBits;
  logic [NUM_BLOCKS-1:0] wrEn;
  logic                  inRange;
  logic [BUS_W-1:0]      byteView [NUM_BYTES];

  assign inRange = (resIndex < IDX_W'(NUM_BLOCKS));

  // One write enable per block
  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_dec
      assign wrEn[b] = resStrobe && inRange && (resIndex == IDX_W'(b));
    end
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_view
      assign byteView[k] = flagBits[k*BUS_W +: BUS_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagBits <= '0;
    end else if (ctl.clr) begin
      flagBits <= '0;
    end else begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        if (wrEn[b]) flagBits[b] <= resFail;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  groupFail <= 1'b0;
    else if (ctl.clr)                           groupFail <= 1'b0;
    else if (resStrobe && inRange && resFail)   groupFail <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         dataOut <= '0;
    else if (ctl.clr)  dataOut <= '0;
    else if (ctl.load) dataOut <= byteView[bytePtr];
  end

  // R4: out-of-range strobes leave every flag alone
  assert_range_ignore_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resStrobe && !inRange && !ctl.clr) |=> $stable(flagBits));

  // R2: summary is sticky until cleared
  assert_sticky_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (groupFail && !ctl.clr) |=> groupFail);

  // R2: an in-range fail raises the summary
  assert_fail_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (resStrobe && inRange && resFail && !ctl.clr) |=> groupFail);

  // R3: a clear empties flags, summary and output
  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (flagBits == '0 && !groupFail && dataOut == '0));

  // R8: output holds while synchronized read-enable stays high
  assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hold && !ctl.clr) |=> $stable(dataOut));

endmodule

// File: rtl/group_status_acc.sv
module group_status_acc #(
  parameter int NUM_BLOCKS  = 64,
  parameter int BUS_W       = 8,
  parameter int IDX_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resStrobe,
  input  logic              resFail,
  input  logic [IDX_W-1:0]  resIndex,
  input  logic              clearAll,
  input  logic              statCmd,
  input  logic              readEn,
  output logic [BUS_W-1:0]  dataOut,
  output logic              groupFail
);

  localparam int NUM_BYTES = NUM_BLOCKS / BUS_W;
  localparam int PTR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  gsa_pkg::ctlStrobe_t ctl;
  logic [PTR_W-1:0]    bytePtr;

  gsa_ctrl #(
    .NUM_BYTES  (NUM_BYTES),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .clearAll(clearAll),
    .statCmd (statCmd),
    .readEn  (readEn),
    .ctl     (ctl),
    .bytePtr (bytePtr)
  );

  gsa_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BUS_W     (BUS_W),
    .IDX_W     (IDX_W)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .bytePtr  (bytePtr),
    .resStrobe(resStrobe),
    .resFail  (resFail),
    .resIndex (resIndex),
    .dataOut  (dataOut),
    .groupFail(groupFail)
  );

endmodule

// File: tb/group_status_acc_tb_top.sv
`timescale 1ns/1ps
module group_status_acc_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       resStrobe = 1'b0;
  logic       resFail = 1'b0;
  logic [6:0] resIndex = '0;
  logic       clearAll = 1'b0;
  logic       statCmd = 1'b0;
  logic       readEn = 1'b1;
  logic [7:0] dataOut;
  logic       groupFail;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;
  logic        modelFail = 1'b0;

  always #10 clk = ~clk;

  group_status_acc dut_i (
    .clk(clk), .rstN(rstN), .resStrobe(resStrobe), .resFail(resFail),
    .resIndex(resIndex), .clearAll(clearAll), .statCmd(statCmd),
    .readEn(readEn), .dataOut(dataOut), .groupFail(groupFail)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic putResult(input int idx, input logic fail);
    @(negedge clk);
    resStrobe = 1'b1; resIndex = 7'(idx); resFail = fail;
    @(negedge clk);
    resStrobe = 1'b0;
    if (idx < 64) begin
      model[idx] = fail;
      if (fail) modelFail = 1'b1;
    end
  endtask

  task automatic pulseCmd();
    @(negedge clk); statCmd = 1'b1;
    @(negedge clk); statCmd = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); clearAll = 1'b1;
    @(negedge clk); clearAll = 1'b0;
    model = '0; modelFail = 1'b0;
  endtask

  // One read-enable toggle; checks the byte and that it holds while high (R8)
  task automatic readByte(input string req, input logic [7:0] exp);
    logic [7:0] got;
    @(negedge clk); readEn = 1'b0;
    repeat (4) @(negedge clk);
    got = dataOut;
    chk(req, got, exp);
    readEn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 hold while high", dataOut, got);
  endtask

  task automatic testReset();
    chk("R9 reset dataOut", dataOut, 8'h00);
    chk("R9 reset groupFail", {7'b0, groupFail}, 8'h00);
    readByte("R9 first read after reset is byte 0", 8'h00);
  endtask

  task automatic testAllPass();
    pulseClear();
    for (int i = 0; i < 64; i++) putResult(i, 1'b0);
    chk("R2 all pass summary", {7'b0, groupFail}, 8'h00);
    pulseCmd();
    for (int k = 0; k < 8; k++) readByte("R5 all pass byte", 8'h00);
  endtask

  task automatic testPattern();
    pulseClear();
    for (int k = 0; k < 8; k++) putResult(9 * k, 1'b1);
    putResult(5, 1'b1);
    chk("R2 fail raises summary", {7'b0, groupFail}, 8'h01);
    putResult(5, 1'b0);
    chk("R2 summary sticky after rewrite", {7'b0, groupFail}, 8'h01);
    pulseCmd();
    for (int k = 0; k < 8; k++) readByte("R1 R5 pattern byte", model[k*8 +: 8]);
    readByte("R7 wrap to byte 0", model[7:0]);
    readByte("R7 byte 1 after wrap", model[15:8]);
  endtask

  task automatic testRestart();
    readByte("R6 pre-restart byte 2", model[23:16]);
    pulseCmd();
    readByte("R6 restart gives byte 0", model[7:0]);
    readByte("R6 then byte 1", model[15:8]);
  endtask

  task automatic testOutOfRange();
    pulseClear();
    putResult(64, 1'b1);
    putResult(127, 1'b1);
    putResult(100, 1'b1);
    chk("R4 summary unchanged", {7'b0, groupFail}, 8'h00);
    pulseCmd();
    for (int k = 0; k < 8; k++) readByte("R4 flags unchanged", 8'h00);
  endtask

  task automatic testClear();
    pulseClear();
    putResult(3, 1'b1);
    putResult(62, 1'b1);
    pulseCmd();
    readByte("R1 byte 0 before clear", 8'h08);
    @(negedge clk);
    clearAll = 1'b1; resStrobe = 1'b1; resIndex = 7'd10; resFail = 1'b1;
    @(negedge clk);
    clearAll = 1'b0; resStrobe = 1'b0;
    model = '0; modelFail = 1'b0;
    chk("R3 clear zeroes summary", {7'b0, groupFail}, 8'h00);
    chk("R3 clear zeroes dataOut", dataOut, 8'h00);
    for (int k = 0; k < 8; k++) readByte("R3 flags empty and pointer at 0", 8'h00);
    putResult(62, 1'b1);
    pulseCmd();
    for (int k = 0; k < 7; k++) readByte("R1 single block bytes", 8'h00);
    readByte("R1 block 62 in bit 6", 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllPass();
    testPattern();
    testRestart();
    testOutOfRange();
    testClear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule